// File: doc/BRIEF.md
# ECC Error Status and Injection Unit

This block sits beside a flash memory controller and an SRAM controller. It does not calculate ECC. Each controller computes its own check bits and sends single-bit and double-bit error pulses, together with the failing address, the syndrome and the ID of the requesting master. The unit keeps the reporting enables for both memories and a write-1-to-clear status word. Each memory has its own capture registers, which hold the details of the first reported error. A per-memory interrupt line is raised while that memory has a status flag set.

Any double-bit error from either memory produces a one-cycle pulse on a fault output for an external fault collector. This pulse is independent of the reporting enables. Software can also corrupt one SRAM write on purpose. It loads XOR masks for the data and check bits and then arms a one-shot injection. The next valid SRAM write passes through the masks, and the injection then disarms itself.

Registers are reached through a simple synchronous port with eight word slots. Write data is taken at the clock edge. Read data is registered.

Top module: `ecc_err_hub`

## Requirements
- R1: After reset every register reads 0, no injection is armed, irq_fl_o, irq_sr_o and fault_o are low, and SRAM write data and check bits pass through unchanged.
- R2: Slot 0 (CONFIG) stores bits [3:0] and reads them back: bit0 enables flash single-bit reporting, bit1 enables flash double-bit reporting, bit2 enables SRAM single-bit reporting, bit3 enables SRAM double-bit reporting. All other bits read 0.
- R3: Slot 1 (STATUS) bit0 is the flash single-bit flag, bit1 the flash double-bit flag, bit2 the SRAM single-bit flag and bit3 the SRAM double-bit flag. An error pulse sets its flag at the clock edge where it is sampled, and only when the matching CONFIG bit is 1.
- R4: Writing 1 to a STATUS bit clears it. Writing 0 leaves it unchanged. An error pulse in the same cycle as the clearing write leaves the flag set.
- R5: When a reported error arrives and no flag of that memory would remain set after any clear in the same cycle, the memory's capture registers load the address, syndrome and master ID. Otherwise they hold their values. Flash uses slots 2 (address) and 3 (syndrome in bits [CHK_W-1:0], master ID in bits [16+MID_W-1:16]).
- R6: SRAM capture uses slots 4 and 5 with the same layout as flash. Errors on one memory never change the other memory's capture registers.
- R7: irq_fl_o is high while STATUS bit0 or bit1 is set. irq_sr_o is high while STATUS bit2 or bit3 is set.
- R8: fault_o is high for exactly the one cycle after any cycle with fl_dbe_i or sr_dbe_i high, whatever the CONFIG bits.
- R9: Slot 6 holds the data XOR mask. Writing slot 7 loads the check-bit XOR mask from bits [8+CHK_W-1:8] and sets the armed state from bit0. While armed, sw_data_o and sw_chk_o are the inputs XORed with the masks. The first cycle with sw_valid_i high while armed disarms the unit. Slot 7 bit0 reads the armed state.
- R10: A read request returns its data on reg_rdata_o after the next clock edge. reg_rdata_o holds that value until the following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register slot |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| fl_sbe_i | input | 1 | Flash single-bit error pulse |
| fl_dbe_i | input | 1 | Flash double-bit error pulse |
| fl_addr_i | input | ADDR_W | Flash error address |
| fl_syn_i | input | CHK_W | Flash syndrome |
| fl_mid_i | input | MID_W | Flash master ID |
| sr_sbe_i | input | 1 | SRAM single-bit error pulse |
| sr_dbe_i | input | 1 | SRAM double-bit error pulse |
| sr_addr_i | input | ADDR_W | SRAM error address |
| sr_syn_i | input | CHK_W | SRAM syndrome |
| sr_mid_i | input | MID_W | SRAM master ID |
| sw_valid_i | input | 1 | SRAM write strobe |
| sw_data_i | input | DATA_W | SRAM write data from the controller |
| sw_chk_i | input | CHK_W | SRAM check bits from the controller |
| sw_data_o | output | DATA_W | Write data after injection |
| sw_chk_o | output | CHK_W | Check bits after injection |
| irq_fl_o | output | 1 | Flash error interrupt |
| irq_sr_o | output | 1 | SRAM error interrupt |
| fault_o | output | 1 | Double-bit error pulse to the fault collector |

## Verification
STATUS, the capture registers and fault_o all update at the edge that samples an error pulse. The bench drives each pulse on a falling edge and checks fault_o at the next falling edge. It checks fault_o again one cycle later to confirm it has dropped. Register reads take one edge, so every STATUS, capture or CONFIG value is read at the falling edge after the request. The injection path is combinational: the bench checks sw_data_o and sw_chk_o a moment after driving a write, before the edge that disarms the unit, and again on the following write.

// File: rtl/ecc_hub_pkg.sv
package ecc_hub_pkg;
   localparam int REG_W   = 32;
   localparam int RA_W    = 3;
   localparam int NUM_MEM = 2;
   localparam int MID_LSB = 16;
   localparam int CMK_LSB = 8;

   typedef enum logic [RA_W-1:0] {
      SLOT_CONFIG = 3'd0,
      SLOT_STATUS = 3'd1,
      SLOT_FL_ADR = 3'd2,
      SLOT_FL_DET = 3'd3,
      SLOT_SR_ADR = 3'd4,
      SLOT_SR_DET = 3'd5,
      SLOT_DMASK  = 3'd6,
      SLOT_INJCTL = 3'd7
   } slot_e;

   localparam int MEM_FL = 0;
   localparam int MEM_SR = 1;
endpackage

// File: rtl/ecc_capture.sv
module ecc_capture #(
   parameter int ADDR_W = 32,
   parameter int CHK_W  = 8,
   parameter int MID_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sbe_i,
   input  logic              dbe_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CHK_W-1:0]  syn_i,
   input  logic [MID_W-1:0]  mid_i,
   input  logic              sbe_en_i,
   input  logic              dbe_en_i,
   input  logic [1:0]        clr_i,
   output logic [1:0]        flags_o,
   output logic [ADDR_W-1:0] cap_addr_o,
   output logic [CHK_W-1:0]  cap_syn_o,
   output logic [MID_W-1:0]  cap_mid_o
);
   logic [1:0]        flags_q;
   logic [1:0]        set_w;
   logic [1:0]        kept_w;
   logic              take_w;
   logic [ADDR_W-1:0] addr_q;
   logic [CHK_W-1:0]  syn_q;
   logic [MID_W-1:0]  mid_q;

   always_comb begin
      set_w  = {dbe_i & dbe_en_i, sbe_i & sbe_en_i};
      kept_w = flags_q & ~clr_i;
      take_w = (|set_w) && (kept_w == 2'b00);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         addr_q  <= '0;
         syn_q   <= '0;
         mid_q   <= '0;
      end else begin
         flags_q <= kept_w | set_w;
         if (take_w) begin
            addr_q <= addr_i;
            syn_q  <= syn_i;
            mid_q  <= mid_i;
         end
      end
   end

   assign flags_o    = flags_q;
   assign cap_addr_o = addr_q;
   assign cap_syn_o  = syn_q;
   assign cap_mid_o  = mid_q;
endmodule

// File: rtl/ecc_inject.sv
module ecc_inject #(
   parameter int DATA_W  = 32,
   parameter int CHK_W   = 8,
   parameter bit INJ_CHK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_i,
   input  logic              arm_i,
   input  logic [CHK_W-1:0]  cmask_i,
   input  logic              dmask_wr_i,
   input  logic [DATA_W-1:0] dmask_i,
   input  logic              wr_valid_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [CHK_W-1:0]  wr_chk_i,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [CHK_W-1:0]  wr_chk_o,
   output logic              armed_o,
   output logic [DATA_W-1:0] dmask_o,
   output logic [CHK_W-1:0]  cmask_o
);
   logic              armed_q;
   logic [DATA_W-1:0] dmask_q;
   logic [CHK_W-1:0]  cmask_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         dmask_q <= '0;
      end else begin
         if (dmask_wr_i) dmask_q <= dmask_i;
         if (ctl_wr_i)        armed_q <= arm_i;
         else if (wr_valid_i) armed_q <= 1'b0;
      end
   end

   generate
      if (INJ_CHK) begin : g_chk_mask
         logic [CHK_W-1:0] cmask_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cmask_q <= '0;
            else if (ctl_wr_i) cmask_q <= cmask_i;
         end
         assign cmask_w = cmask_q;
      end else begin : g_no_chk_mask
         logic [CHK_W-1:0] unused_cmask;
         assign unused_cmask = cmask_i;
         assign cmask_w      = '0;
      end
   endgenerate

   assign wr_data_o = armed_q ? (wr_data_i ^ dmask_q) : wr_data_i;
   assign wr_chk_o  = armed_q ? (wr_chk_i ^ cmask_w) : wr_chk_i;
   assign armed_o   = armed_q;
   assign dmask_o   = dmask_q;
   assign cmask_o   = cmask_w;
endmodule

// File: rtl/ecc_err_hub.sv
module ecc_err_hub
   import ecc_hub_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int CHK_W   = 8,
   parameter int MID_W   = 4,
   parameter bit RD_REG  = 1'b1,
   parameter bit INJ_CHK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_en_i,
   input  logic              reg_we_i,
   input  logic [RA_W-1:0]   reg_addr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   input  logic              fl_sbe_i,
   input  logic              fl_dbe_i,
   input  logic [ADDR_W-1:0] fl_addr_i,
   input  logic [CHK_W-1:0]  fl_syn_i,
   input  logic [MID_W-1:0]  fl_mid_i,
   input  logic              sr_sbe_i,
   input  logic              sr_dbe_i,
   input  logic [ADDR_W-1:0] sr_addr_i,
   input  logic [CHK_W-1:0]  sr_syn_i,
   input  logic [MID_W-1:0]  sr_mid_i,
   input  logic              sw_valid_i,
   input  logic [DATA_W-1:0] sw_data_i,
   input  logic [CHK_W-1:0]  sw_chk_i,
   output logic [DATA_W-1:0] sw_data_o,
   output logic [CHK_W-1:0]  sw_chk_o,
   output logic              irq_fl_o,
   output logic              irq_sr_o,
   output logic              fault_o
);
   localparam int FLAG_W = 2 * NUM_MEM;

   generate
      if (ADDR_W < 1 || ADDR_W > REG_W) begin : g_bad_addr
         $error("ADDR_W must be 1..32");
      end
      if (DATA_W < 1 || DATA_W > REG_W) begin : g_bad_data
         $error("DATA_W must be 1..32");
      end
      if (CHK_W < 1 || CHK_W > MID_LSB - CMK_LSB) begin : g_bad_chk
         $error("CHK_W must be 1..8");
      end
      if (MID_W < 1 || MID_W > REG_W - MID_LSB) begin : g_bad_mid
         $error("MID_W must be 1..16");
      end
   endgenerate

   logic              wr_w;
   logic              rd_w;
   logic [FLAG_W-1:0] cfg_q;
   logic [FLAG_W-1:0] stat_w;
   logic              stat_wr;
   logic              fault_q;
   logic [REG_W-1:0]  rd_mux;

   logic              ev_sbe [NUM_MEM];
   logic              ev_dbe [NUM_MEM];
   logic [ADDR_W-1:0] ev_addr [NUM_MEM];
   logic [CHK_W-1:0]  ev_syn [NUM_MEM];
   logic [MID_W-1:0]  ev_mid [NUM_MEM];
   logic [1:0]        flags_w [NUM_MEM];
   logic [ADDR_W-1:0] cap_addr [NUM_MEM];
   logic [CHK_W-1:0]  cap_syn [NUM_MEM];
   logic [MID_W-1:0]  cap_mid [NUM_MEM];

   logic              inj_armed;
   logic [DATA_W-1:0] inj_dmask;
   logic [CHK_W-1:0]  inj_cmask;
   logic [ADDR_W-1:0] fl_cap_addr;
   logic [ADDR_W-1:0] sr_cap_addr;

   assign wr_w    = reg_en_i & reg_we_i;
   assign rd_w    = reg_en_i & ~reg_we_i;
   assign stat_wr = wr_w && (reg_addr_i == SLOT_STATUS);

   always_comb begin
      ev_sbe[MEM_FL]  = fl_sbe_i;
      ev_dbe[MEM_FL]  = fl_dbe_i;
      ev_addr[MEM_FL] = fl_addr_i;
      ev_syn[MEM_FL]  = fl_syn_i;
      ev_mid[MEM_FL]  = fl_mid_i;
      ev_sbe[MEM_SR]  = sr_sbe_i;
      ev_dbe[MEM_SR]  = sr_dbe_i;
      ev_addr[MEM_SR] = sr_addr_i;
      ev_syn[MEM_SR]  = sr_syn_i;
      ev_mid[MEM_SR]  = sr_mid_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         if (wr_w && reg_addr_i == SLOT_CONFIG) cfg_q <= reg_wdata_i[FLAG_W-1:0];
         fault_q <= fl_dbe_i | sr_dbe_i;
      end
   end

   generate
      for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
         logic [1:0] clr_w;
         assign clr_w = stat_wr ? reg_wdata_i[2*g +: 2] : 2'b00;

         ecc_capture #(
            .ADDR_W(ADDR_W),
            .CHK_W (CHK_W),
            .MID_W (MID_W)
         ) i_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .sbe_i     (ev_sbe[g]),
            .dbe_i     (ev_dbe[g]),
            .addr_i    (ev_addr[g]),
            .syn_i     (ev_syn[g]),
            .mid_i     (ev_mid[g]),
            .sbe_en_i  (cfg_q[2*g]),
            .dbe_en_i  (cfg_q[2*g+1]),
            .clr_i     (clr_w),
            .flags_o   (flags_w[g]),
            .cap_addr_o(cap_addr[g]),
            .cap_syn_o (cap_syn[g]),
            .cap_mid_o (cap_mid[g])
         );

         assign stat_w[2*g +: 2] = flags_w[g];
      end
   endgenerate

   ecc_inject #(
      .DATA_W (DATA_W),
      .CHK_W  (CHK_W),
      .INJ_CHK(INJ_CHK)
   ) i_inj (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr_i  (wr_w && reg_addr_i == SLOT_INJCTL),
      .arm_i     (reg_wdata_i[0]),
      .cmask_i   (reg_wdata_i[CMK_LSB +: CHK_W]),
      .dmask_wr_i(wr_w && reg_addr_i == SLOT_DMASK),
      .dmask_i   (reg_wdata_i[DATA_W-1:0]),
      .wr_valid_i(sw_valid_i),
      .wr_data_i (sw_data_i),
      .wr_chk_i  (sw_chk_i),
      .wr_data_o (sw_data_o),
      .wr_chk_o  (sw_chk_o),
      .armed_o   (inj_armed),
      .dmask_o   (inj_dmask),
      .cmask_o   (inj_cmask)
   );

   assign fl_cap_addr = cap_addr[MEM_FL];
   assign sr_cap_addr = cap_addr[MEM_SR];

   logic [REG_W-1:0] unused_wdata;
   assign unused_wdata = reg_wdata_i;

   always_comb begin
      rd_mux = '0;
      unique case (slot_e'(reg_addr_i))
         SLOT_CONFIG: rd_mux[FLAG_W-1:0] = cfg_q;
         SLOT_STATUS: rd_mux[FLAG_W-1:0] = stat_w;
         SLOT_FL_ADR: rd_mux[ADDR_W-1:0] = cap_addr[MEM_FL];
         SLOT_FL_DET: begin
            rd_mux[CHK_W-1:0]        = cap_syn[MEM_FL];
            rd_mux[MID_LSB +: MID_W] = cap_mid[MEM_FL];
         end
         SLOT_SR_ADR: rd_mux[ADDR_W-1:0] = cap_addr[MEM_SR];
         SLOT_SR_DET: begin
            rd_mux[CHK_W-1:0]        = cap_syn[MEM_SR];
            rd_mux[MID_LSB +: MID_W] = cap_mid[MEM_SR];
         end
         SLOT_DMASK:  rd_mux[DATA_W-1:0] = inj_dmask;
         SLOT_INJCTL: begin
            rd_mux[0]                = inj_armed;
            rd_mux[CMK_LSB +: CHK_W] = inj_cmask;
         end
         default:     rd_mux = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_reg
         logic [REG_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    rdata_q <= '0;
            else if (rd_w) rdata_q <= rd_mux;
         end
         assign reg_rdata_o = rdata_q;
      end else begin : g_rd_comb
         logic unused_rd;
         assign unused_rd   = rd_w;
         assign reg_rdata_o = rd_mux;
      end
   endgenerate

   assign irq_fl_o = |stat_w[1:0];
   assign irq_sr_o = |stat_w[3:2];
   assign fault_o  = fault_q;
endmodule

// File: rtl/ecc_hub_chk.sv
module ecc_hub_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fl_sbe_i,
   input logic              fl_dbe_i,
   input logic              sr_dbe_i,
   input logic              fault_o,
   input logic [3:0]        cfg_q,
   input logic [3:0]        stat_w,
   input logic              stat_wr,
   input logic [ADDR_W-1:0] fl_cap_addr,
   input logic [ADDR_W-1:0] sr_cap_addr,
   input logic              sr_sbe_i,
   input logic              inj_armed,
   input logic [DATA_W-1:0] sw_data_i,
   input logic [DATA_W-1:0] sw_data_o
);
   // R8
   fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_dbe_i || sr_dbe_i) |=> fault_o);

   // R8
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_dbe_i || sr_dbe_i) |=> !fault_o);

   // R3
   flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_w[0]) |-> $past(fl_sbe_i && cfg_q[0]));

   // R5
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_w[1:0] != 2'b00 && !stat_wr) |=> $stable(fl_cap_addr));

   // R6
   cap_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_sbe_i && !sr_dbe_i) |=> $stable(sr_cap_addr));

   // R9
   inj_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inj_armed |-> (sw_data_o == sw_data_i));
endmodule

bind ecc_err_hub ecc_hub_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fl_sbe_i   (fl_sbe_i),
   .fl_dbe_i   (fl_dbe_i),
   .sr_dbe_i   (sr_dbe_i),
   .fault_o    (fault_o),
   .cfg_q      (cfg_q),
   .stat_w     (stat_w),
   .stat_wr    (stat_wr),
   .fl_cap_addr(fl_cap_addr),
   .sr_cap_addr(sr_cap_addr),
   .sr_sbe_i   (sr_sbe_i),
   .inj_armed  (inj_armed),
   .sw_data_i  (sw_data_i),
   .sw_data_o  (sw_data_o)
);

// File: tb/test_ecc_err_hub.sv
module test_ecc_err_hub;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;
   localparam int CHK_W  = 8;
   localparam int MID_W  = 4;

   typedef struct packed {
      logic [3:0] cfg;
      logic [3:0] ev;
      logic [3:0] exp_stat;
      logic       exp_fault;
   } vec_t;

   // ev bits: 0 fl single, 1 fl double, 2 sr single, 3 sr double
   localparam vec_t VECS [8] = '{
      '{4'hF, 4'h1, 4'h1, 1'b0},
      '{4'hF, 4'h2, 4'h2, 1'b1},
      '{4'hF, 4'h4, 4'h4, 1'b0},
      '{4'hF, 4'h8, 4'h8, 1'b1},
      '{4'h0, 4'h2, 4'h0, 1'b1},
      '{4'h0, 4'hF, 4'h0, 1'b1},
      '{4'h5, 4'hF, 4'h5, 1'b1},
      '{4'hA, 4'h3, 4'h2, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_en = 1'b0, reg_we = 1'b0;
   logic [2:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              fl_sbe = 1'b0, fl_dbe = 1'b0, sr_sbe = 1'b0, sr_dbe = 1'b0;
   logic [ADDR_W-1:0] fl_addr = '0, sr_addr = '0;
   logic [CHK_W-1:0]  fl_syn = '0, sr_syn = '0;
   logic [MID_W-1:0]  fl_mid = '0, sr_mid = '0;
   logic              sw_valid = 1'b0;
   logic [DATA_W-1:0] sw_data = '0, sw_data_o;
   logic [CHK_W-1:0]  sw_chk = '0, sw_chk_o;
   logic              irq_fl, irq_sr, fault;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_err_hub i_ecc_err_hub (
      .clk(clk), .rst_n(rst_n),
      .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .fl_sbe_i(fl_sbe), .fl_dbe_i(fl_dbe), .fl_addr_i(fl_addr),
      .fl_syn_i(fl_syn), .fl_mid_i(fl_mid),
      .sr_sbe_i(sr_sbe), .sr_dbe_i(sr_dbe), .sr_addr_i(sr_addr),
      .sr_syn_i(sr_syn), .sr_mid_i(sr_mid),
      .sw_valid_i(sw_valid), .sw_data_i(sw_data), .sw_chk_i(sw_chk),
      .sw_data_o(sw_data_o), .sw_chk_o(sw_chk_o),
      .irq_fl_o(irq_fl), .irq_sr_o(irq_sr), .fault_o(fault)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_en = 1'b0; reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
      @(posedge clk); @(negedge clk);
      reg_en = 1'b0;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [3:0] ev);
      {sr_dbe, sr_sbe, fl_dbe, fl_sbe} = ev;
      @(posedge clk); @(negedge clk);
      {sr_dbe, sr_sbe, fl_dbe, fl_sbe} = 4'h0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         chk($sformatf("R1 slot %0d", a), v, 32'h0);
      end
      chk("R1 irq/fault", {29'h0, irq_fl, irq_sr, fault}, 32'h0);
      sw_data = 32'hCAFE_F00D; sw_chk = 8'hA5; #1;
      chk("R1 data pass", sw_data_o, 32'hCAFE_F00D);
      chk("R1 chk pass", {24'h0, sw_chk_o}, 32'hA5);

      // R3 R7 R8 vector walk
      for (int i = 0; i < 8; i++) begin
         wr(3'd0, {28'h0, VECS[i].cfg});
         wr(3'd1, 32'hF);
         pulse(VECS[i].ev);
         chk($sformatf("R8 fault vec %0d", i), {31'h0, fault}, {31'h0, VECS[i].exp_fault});
         chk($sformatf("R7 irq vec %0d", i), {30'h0, irq_fl, irq_sr},
             {30'h0, |VECS[i].exp_stat[1:0], |VECS[i].exp_stat[3:2]});
         rd(3'd1, v);
         chk($sformatf("R3 status vec %0d", i), v, {28'h0, VECS[i].exp_stat});
         chk($sformatf("R8 fault drop vec %0d", i), {31'h0, fault}, 32'h0);
      end

      // R2 config readback
      wr(3'd0, 32'hFFFF_FFFA);
      rd(3'd0, v);
      chk("R2 config", v, 32'hA);

      // R10 read data is registered
      reg_en = 1'b1; reg_we = 1'b0; reg_addr = 3'd6; #1;
      chk("R10 hold before edge", v, reg_rdata);
      @(posedge clk); @(negedge clk); reg_en = 1'b0;
      chk("R10 new data after edge", reg_rdata, 32'h0);

      // R5 capture first event, hold while flagged
      wr(3'd0, 32'hF);
      wr(3'd1, 32'hF);
      fl_addr = 32'h0000_A100; fl_syn = 8'h11; fl_mid = 4'h3;
      pulse(4'h1);
      fl_addr = 32'h0000_A200; fl_syn = 8'h22; fl_mid = 4'h5;
      pulse(4'h2);
      rd(3'd2, v); chk("R5 first addr kept", v, 32'h0000_A100);
      rd(3'd3, v); chk("R5 detail layout", v, 32'h0003_0011);
      wr(3'd1, 32'h1);
      rd(3'd1, v); chk("R4 partial clear", v, 32'h2);
      fl_addr = 32'h0000_A300;
      pulse(4'h1);
      rd(3'd2, v); chk("R5 held while flagged", v, 32'h0000_A100);
      wr(3'd1, 32'h0);
      rd(3'd1, v); chk("R4 write zero no effect", v, 32'h3);
      wr(3'd1, 32'h3);
      rd(3'd1, v); chk("R4 clear all", v, 32'h0);
      fl_addr = 32'h0000_A400; fl_syn = 8'h44; fl_mid = 4'h9;
      pulse(4'h1);
      rd(3'd2, v); chk("R5 recapture", v, 32'h0000_A400);

      // R4 set wins over same-cycle clear, with recapture
      fl_addr = 32'h0000_A500;
      reg_en = 1'b1; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h1;
      fl_sbe = 1'b1;
      @(posedge clk); @(negedge clk);
      reg_en = 1'b0; reg_we = 1'b0; fl_sbe = 1'b0;
      rd(3'd1, v); chk("R4 set wins", v, 32'h1);
      rd(3'd2, v); chk("R5 capture on clear+event", v, 32'h0000_A500);

      // R6 separate SRAM capture
      sr_addr = 32'h0000_B100; sr_syn = 8'h7E; sr_mid = 4'h2;
      pulse(4'h8);
      rd(3'd4, v); chk("R6 sram addr", v, 32'h0000_B100);
      rd(3'd5, v); chk("R6 sram detail", v, 32'h0002_007E);
      rd(3'd2, v); chk("R6 flash untouched", v, 32'h0000_A500);

      // R9 injection
      wr(3'd6, 32'h0000_0101);
      wr(3'd7, 32'h0000_5A01);
      rd(3'd7, v); chk("R9 ctl armed", v, 32'h0000_5A01);
      sw_data = 32'h1234_5678; sw_chk = 8'h33; sw_valid = 1'b1; #1;
      chk("R9 data xor", sw_data_o, 32'h1234_5779);
      chk("R9 chk xor", {24'h0, sw_chk_o}, 32'h69);
      @(posedge clk); @(negedge clk);
      chk("R9 second write clean", sw_data_o, 32'h1234_5678);
      chk("R9 second chk clean", {24'h0, sw_chk_o}, 32'h33);
      sw_valid = 1'b0;
      rd(3'd7, v); chk("R9 disarmed", v, 32'h0000_5A00);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule